// File: doc/BRIEF.md
# SPI Channel Word-Exchange Controller

This block runs one channel of a multi-channel SPI master. It keeps the channel's configuration word, enable bit, status flags, transmit word and receive word. It decides when a word exchange may begin. It hands each exchange to an external serial shift engine through a start / word-length / done handshake. When an exchange ends, it updates the flags, drives the transmit and receive DMA request lines, and pulses interrupt events.

Software access reaches the block as decoded strobes: configuration write, enable write, transmit write and receive read. All of them share one write-data bus. The stored state is presented on output ports so that a register file above can return it on reads. A module-level single-channel input says whether words are actually shifted. The flag bookkeeping runs either way.

Top module: `spi_chan_ctrl`

## Requirements
- R1: After reset the configuration reads 0x060000 and the status reads 3'b010. In status, bit 0 is receive-full, bit 1 is transmit-empty and bit 2 is end-of-transfer. Enable, the transmit word, the receive word, the start, DMA request and interrupt event outputs are all 0.
- R2: A configuration write stores the low 23 bits of the write data. The error output is high while the word-length field (bits 11:7) is below 3, and the value is stored anyway.
- R3: An enable write stores bit 0 of the write data. Only a 0-to-1 change of enable triggers an exchange attempt. No exchange starts while enable is 0.
- R4: The transfer mode sits in configuration bits 13:12: 0 is duplex, 1 is receive-only, 2 is transmit-only, and 3 acts as duplex. An attempt is refused while receive-full is set, the mode is not 2 and turbo (bit 19) is 0. An attempt is also refused while transmit-empty is set and the mode is not 1.
- R5: A transmit write stores the full data word, clears transmit-empty and triggers an attempt. A receive read clears receive-full and triggers an attempt. The receive word seen during the read strobe is the one held before the read.
- R6: An accepted attempt shifts a word only when the single-channel input is 0 or the force bit (bit 20) is 1. In that case it pulses the start output with the word length equal to bits 11:7 and the data equal to the transmit word. The receive word then takes the engine's data at done. Without a shift, the receive word is unchanged.
- R7: When an exchange completes, the transmit word becomes 0 and end-of-transfer and transmit-empty are set. Receive-full is also set unless the mode is 2.
- R8: The transmit DMA request equals enable AND bit 14 AND transmit-empty AND mode≠1. The receive DMA request equals enable AND bit 15 AND receive-full AND mode≠2.
- R9: Each enabled attempt that ends, whether refused or completed, can emit one-cycle event pulses. The receive event fires when receive-full is set, the mode is not 2 and turbo is 0. The transmit event fires when transmit-empty is set and the mode is not 1. An attempt made while disabled emits nothing.
- R10: A trigger that arrives while the shift engine is busy is held. It is evaluated after done, and only one exchange is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| solo_mode | input | 1 | Module single-channel mode; when 1, only forced channels shift |
| cfg_wr | input | 1 | Configuration write strobe |
| ctrl_wr | input | 1 | Enable write strobe |
| tx_wr | input | 1 | Transmit word write strobe |
| rx_rd | input | 1 | Receive word read strobe |
| wdata | input | DATA_W | Write data shared by all write strobes |
| cfg_q | output | 23 | Stored configuration |
| stat_q | output | 3 | Status flags {end-of-transfer, transmit-empty, receive-full} |
| en_q | output | 1 | Channel enable |
| tx_q | output | DATA_W | Transmit word |
| rx_q | output | DATA_W | Receive word |
| wl_err | output | 1 | Word-length field below 3 |
| shift_start | output | 1 | One-cycle request to the shift engine |
| shift_wlen | output | 5 | Word length minus one for the engine |
| shift_txd | output | DATA_W | Word to shift out |
| shift_rxd | input | DATA_W | Word shifted in, valid with done |
| shift_done | input | 1 | Engine finished the exchange |
| tx_dreq | output | 1 | Transmit DMA request level |
| rx_dreq | output | 1 | Receive DMA request level |
| irq_tx_ev | output | 1 | Transmit-empty interrupt event pulse |
| irq_rx_ev | output | 1 | Receive-full interrupt event pulse |

## Verification
The bench builds the block with DATA_W at 32. Every configuration bit can then be written, and full 32-bit words travel through the transmit and receive paths, so a dropped or swapped half-word shows up in the data. The modelled shift engine answers three cycles after start. This latency leaves a window in which a receive read can land while an exchange is in flight, which is what brings the deferred re-evaluation of R10 within reach. Random configurations cover all four mode codes and the turbo, force and DMA bits. The single-channel input is toggled as well, so refused, shifted and flag-only completions all occur.

// File: rtl/spi_chan_pkg.sv
// Shared field positions, reset value and types for the SPI channel controller.
// Assumes a 23-bit configuration word with the layout given in the brief.
package spi_chan_pkg;
    localparam int CFG_W      = 23;
    localparam int WL_W       = 5;
    localparam int WL_LSB     = 7;
    localparam int MODE_LSB   = 12;
    localparam int DMA_TX_BIT = 14;
    localparam int DMA_RX_BIT = 15;
    localparam int TURBO_BIT  = 19;
    localparam int FORCE_BIT  = 20;
    localparam int WL_MIN     = 3;
    localparam logic [CFG_W-1:0] CFG_RST = 23'h060000;

    typedef enum logic [1:0] {
        MODE_DUPLEX  = 2'd0,
        MODE_RX_ONLY = 2'd1,
        MODE_TX_ONLY = 2'd2,
        MODE_BAD     = 2'd3
    } xfer_mode_e;

    // Packed MSB first: eot is bit 2, txe bit 1, rxf bit 0.
    typedef struct packed {
        logic eot;
        logic txe;
        logic rxf;
    } chan_stat_t;

    localparam chan_stat_t STAT_RST = '{eot: 1'b0, txe: 1'b1, rxf: 1'b0};
endpackage

// File: rtl/spi_chan_cfg.sv
// Configuration and enable storage. Decodes the fields the sequencer needs and
// detects the enable rising edge. Assumes write strobes are single-cycle.
module spi_chan_cfg
    import spi_chan_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             ctrl_wr,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] cfg_q,
    output logic             en_q,
    output logic             en_rise,
    output xfer_mode_e       mode,
    output logic             turbo,
    output logic             force_sh,
    output logic             dma_tx_en,
    output logic             dma_rx_en,
    output logic [WL_W-1:0]  wlen,
    output logic             wl_err
);
    // Store the configuration word and the enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= CFG_RST;
            en_q  <= 1'b0;
        end else begin
            if (cfg_wr)  cfg_q <= wdata;
            if (ctrl_wr) en_q  <= wdata[0];
        end
    end

    // Field decode and enable-edge detection.
    always_comb begin
        en_rise   = ctrl_wr && wdata[0] && !en_q;
        mode      = xfer_mode_e'(cfg_q[MODE_LSB +: 2]);
        turbo     = cfg_q[TURBO_BIT];
        force_sh  = cfg_q[FORCE_BIT];
        dma_tx_en = cfg_q[DMA_TX_BIT];
        dma_rx_en = cfg_q[DMA_RX_BIT];
        wlen      = cfg_q[WL_LSB +: WL_W];
        wl_err    = (wlen < WL_W'(WL_MIN));
    end

    a_r2_cfg_stored: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (cfg_q == $past(wdata)));
endmodule

// File: rtl/spi_chan_xfer.sv
// Exchange sequencer. Holds the status flags and the data words, and tracks a
// pending attempt and a busy shift. It starts the engine and applies the
// completion updates and interrupt events. Assumes shift_done is ignored unless busy.
module spi_chan_xfer
    import spi_chan_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              en_rise,
    input  xfer_mode_e        mode,
    input  logic              turbo,
    input  logic              force_sh,
    input  logic              solo_mode,
    input  logic              tx_wr,
    input  logic              rx_rd,
    input  logic [DATA_W-1:0] wdata,
    input  logic              shift_done,
    input  logic [DATA_W-1:0] shift_rxd,
    output logic              shift_start,
    output chan_stat_t        stat_q,
    output logic [DATA_W-1:0] tx_q,
    output logic [DATA_W-1:0] rx_q,
    output logic              irq_tx_ev,
    output logic              irq_rx_ev
);
    logic       pend_q, busy_q;
    logic       rx_block, tx_block, eval, go, shifting, finish, ev_win, trig;
    logic       landed;
    chan_stat_t stat_n;

    // Gate decisions, completion and next status.
    always_comb begin
        rx_block    = stat_q.rxf && (mode != MODE_TX_ONLY) && !turbo;
        tx_block    = stat_q.txe && (mode != MODE_RX_ONLY);
        eval        = pend_q && !busy_q;
        go          = eval && en && !rx_block && !tx_block;
        shifting    = !solo_mode || force_sh;
        shift_start = go && shifting;
        landed      = busy_q && shift_done;
        finish      = (go && !shifting) || landed;
        ev_win      = (eval && en && !shift_start) || landed;
        trig        = en_rise || tx_wr || rx_rd;
        stat_n      = stat_q;
        if (finish) begin
            stat_n.eot = 1'b1;
            stat_n.txe = 1'b1;
            if (mode != MODE_TX_ONLY) stat_n.rxf = 1'b1;
        end
        if (tx_wr) stat_n.txe = 1'b0;
        if (rx_rd) stat_n.rxf = 1'b0;
    end

    // Pending attempt and busy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            busy_q <= 1'b0;
        end else begin
            if (trig)      pend_q <= 1'b1;
            else if (eval) pend_q <= 1'b0;
            if (shift_start)     busy_q <= 1'b1;
            else if (shift_done) busy_q <= 1'b0;
        end
    end

    // Status flags, data words and event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q    <= STAT_RST;
            tx_q      <= '0;
            rx_q      <= '0;
            irq_tx_ev <= 1'b0;
            irq_rx_ev <= 1'b0;
        end else begin
            stat_q <= stat_n;
            if (tx_wr)       tx_q <= wdata;
            else if (finish) tx_q <= '0;
            if (landed) rx_q <= shift_rxd;
            irq_rx_ev <= ev_win && stat_n.rxf && (mode != MODE_TX_ONLY) && !turbo;
            irq_tx_ev <= ev_win && stat_n.txe && (mode != MODE_RX_ONLY);
        end
    end

    a_r3_no_start_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        shift_start |-> en);
    a_r10_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> !shift_start);
    a_r7_done_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && shift_done && !tx_wr) |=> (stat_q.txe && stat_q.eot));
    a_r5_txwr_clears: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr |=> !stat_q.txe);
    a_r9_tx_ev_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx_ev |-> stat_q.txe);
    a_r9_rx_ev_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx_ev |-> stat_q.rxf);
endmodule

// File: rtl/spi_chan_dreq.sv
// DMA request levels derived from enable, DMA enables, mode and status.
// Purely combinational; assumes registered inputs.
module spi_chan_dreq
    import spi_chan_pkg::*;
(
    input  logic       en,
    input  logic       dma_tx_en,
    input  logic       dma_rx_en,
    input  xfer_mode_e mode,
    input  chan_stat_t stat,
    output logic       tx_dreq,
    output logic       rx_dreq
);
    // Request lines follow the current channel state.
    always_comb begin
        tx_dreq = en && dma_tx_en && stat.txe && (mode != MODE_RX_ONLY);
        rx_dreq = en && dma_rx_en && stat.rxf && (mode != MODE_TX_ONLY);
    end
endmodule

// File: rtl/spi_chan_ctrl.sv
// Top of one SPI channel controller: configuration store, exchange sequencer and
// DMA request logic. Assumes decoded single-cycle strobes and an external shift
// engine that answers start with exactly one done pulse.
module spi_chan_ctrl
    import spi_chan_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              solo_mode,
    input  logic              cfg_wr,
    input  logic              ctrl_wr,
    input  logic              tx_wr,
    input  logic              rx_rd,
    input  logic [DATA_W-1:0] wdata,
    output logic [CFG_W-1:0]  cfg_q,
    output logic [2:0]        stat_q,
    output logic              en_q,
    output logic [DATA_W-1:0] tx_q,
    output logic [DATA_W-1:0] rx_q,
    output logic              wl_err,
    output logic              shift_start,
    output logic [WL_W-1:0]   shift_wlen,
    output logic [DATA_W-1:0] shift_txd,
    input  logic [DATA_W-1:0] shift_rxd,
    input  logic              shift_done,
    output logic              tx_dreq,
    output logic              rx_dreq,
    output logic              irq_tx_ev,
    output logic              irq_rx_ev
);
    xfer_mode_e mode;
    logic       en_rise, turbo, force_sh, dma_tx_en, dma_rx_en;
    chan_stat_t stat;

    spi_chan_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .ctrl_wr   (ctrl_wr),
        .wdata     (wdata[CFG_W-1:0]),
        .cfg_q     (cfg_q),
        .en_q      (en_q),
        .en_rise   (en_rise),
        .mode      (mode),
        .turbo     (turbo),
        .force_sh  (force_sh),
        .dma_tx_en (dma_tx_en),
        .dma_rx_en (dma_rx_en),
        .wlen      (shift_wlen),
        .wl_err    (wl_err)
    );

    spi_chan_xfer #(.DATA_W(DATA_W)) u_xfer (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en_q),
        .en_rise     (en_rise),
        .mode        (mode),
        .turbo       (turbo),
        .force_sh    (force_sh),
        .solo_mode   (solo_mode),
        .tx_wr       (tx_wr),
        .rx_rd       (rx_rd),
        .wdata       (wdata),
        .shift_done  (shift_done),
        .shift_rxd   (shift_rxd),
        .shift_start (shift_start),
        .stat_q      (stat),
        .tx_q        (tx_q),
        .rx_q        (rx_q),
        .irq_tx_ev   (irq_tx_ev),
        .irq_rx_ev   (irq_rx_ev)
    );

    spi_chan_dreq u_dreq (
        .en        (en_q),
        .dma_tx_en (dma_tx_en),
        .dma_rx_en (dma_rx_en),
        .mode      (mode),
        .stat      (stat),
        .tx_dreq   (tx_dreq),
        .rx_dreq   (rx_dreq)
    );

    // Present the flags as a plain vector.
    always_comb stat_q = stat;

    assign shift_txd = tx_q;

    a_r8_dreq_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_dreq || rx_dreq) |-> en_q);
endmodule

// File: tb/sim_spi_chan_ctrl.sv
// Self-checking bench: directed corners plus seeded random operations, compared
// against a transaction-level model kept in bench tasks.
module sim_spi_chan_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int ENG_LAT    = 3;
    localparam int SETTLE     = 10;
    localparam int N_RANDOM   = 400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        solo_mode = 1'b0;
    logic        cfg_wr = 1'b0, ctrl_wr = 1'b0, tx_wr = 1'b0, rx_rd = 1'b0;
    logic [31:0] wdata = '0;
    logic [22:0] cfg_q;
    logic [2:0]  stat_q;
    logic        en_q, wl_err, shift_start, shift_done, tx_dreq, rx_dreq;
    logic        irq_tx_ev, irq_rx_ev;
    logic [31:0] tx_q, rx_q, shift_txd, shift_rxd;
    logic [4:0]  shift_wlen;

    int checks = 0, fails = 0;
    int n_start = 0, ev_tx = 0, ev_rx = 0;
    logic [4:0]  cap_wl;
    logic [31:0] cap_tx;

    // model state
    logic [22:0] m_cfg = 23'h060000;
    logic [2:0]  m_stat = 3'b010;
    logic        m_en = 1'b0;
    logic [31:0] m_tx = '0, m_rx = '0;
    int          e_start, e_tx, e_rx;

    spi_chan_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .solo_mode(solo_mode), .cfg_wr(cfg_wr),
        .ctrl_wr(ctrl_wr), .tx_wr(tx_wr), .rx_rd(rx_rd), .wdata(wdata),
        .cfg_q(cfg_q), .stat_q(stat_q), .en_q(en_q), .tx_q(tx_q), .rx_q(rx_q),
        .wl_err(wl_err), .shift_start(shift_start), .shift_wlen(shift_wlen),
        .shift_txd(shift_txd), .shift_rxd(shift_rxd), .shift_done(shift_done),
        .tx_dreq(tx_dreq), .rx_dreq(rx_dreq), .irq_tx_ev(irq_tx_ev),
        .irq_rx_ev(irq_rx_ev)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] scramble(input logic [31:0] x);
        return {x[15:0], x[31:16]} ^ 32'hA5C3_0F96;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // shift engine model: answers each start after ENG_LAT cycles
    initial begin
        int cnt;
        cnt = 0;
        shift_done = 1'b0;
        shift_rxd  = '0;
        forever begin
            @(negedge clk);
            if (shift_done) shift_done = 1'b0;
            if (cnt > 0) begin
                cnt--;
                if (cnt == 0) begin
                    shift_rxd  = scramble(cap_tx);
                    shift_done = 1'b1;
                end
            end else if (shift_start === 1'b1) begin
                cap_tx = shift_txd;
                cap_wl = shift_wlen;
                n_start++;
                cnt = ENG_LAT;
            end
        end
    end

    // event pulse counters
    initial forever begin
        @(negedge clk);
        if (irq_tx_ev === 1'b1) ev_tx++;
        if (irq_rx_ev === 1'b1) ev_rx++;
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // model of one attempt: R3, R4, R6, R7, R9
    task automatic model_run();
        logic [1:0] md;
        bit         blk;
        md = m_cfg[13:12];
        if (!m_en) return;
        blk = (m_stat[0] && md != 2'd2 && !m_cfg[19]) || (m_stat[1] && md != 2'd1);
        if (!blk) begin
            if (!solo_mode || m_cfg[20]) begin
                m_rx = scramble(m_tx);
                e_start++;
            end
            m_tx = '0;
            m_stat[2] = 1'b1;
            m_stat[1] = 1'b1;
            if (md != 2'd2) m_stat[0] = 1'b1;
        end
        if (m_stat[0] && md != 2'd2 && !m_cfg[19]) e_rx++;
        if (m_stat[1] && md != 2'd1) e_tx++;
    endtask

    task automatic settle_and_compare(input int s0, input int t0, input int r0);
        logic [1:0] md;
        repeat (SETTLE) @(negedge clk);
        md = m_cfg[13:12];
        check(cfg_q == m_cfg, "R2", "config", 32'(cfg_q), 32'(m_cfg));
        check(wl_err == (m_cfg[11:7] < 5'd3), "R2", "wl_err", 32'(wl_err),
              32'(m_cfg[11:7] < 5'd3));
        check(en_q == m_en, "R3", "enable", 32'(en_q), 32'(m_en));
        check(stat_q == m_stat, "R7", "status", 32'(stat_q), 32'(m_stat));
        check(tx_q == m_tx, "R5", "tx word", tx_q, m_tx);
        check(rx_q == m_rx, "R6", "rx word", rx_q, m_rx);
        check(tx_dreq == (m_en && m_cfg[14] && m_stat[1] && md != 2'd1), "R8",
              "tx_dreq", 32'(tx_dreq), 32'(m_en && m_cfg[14] && m_stat[1] && md != 2'd1));
        check(rx_dreq == (m_en && m_cfg[15] && m_stat[0] && md != 2'd2), "R8",
              "rx_dreq", 32'(rx_dreq), 32'(m_en && m_cfg[15] && m_stat[0] && md != 2'd2));
        check(n_start - s0 == e_start, "R4", "starts", 32'(n_start - s0), 32'(e_start));
        check(ev_tx - t0 == e_tx, "R9", "tx events", 32'(ev_tx - t0), 32'(e_tx));
        check(ev_rx - r0 == e_rx, "R9", "rx events", 32'(ev_rx - r0), 32'(e_rx));
        if (e_start > 0)
            check(cap_wl == m_cfg[11:7], "R6", "shift wlen", 32'(cap_wl), 32'(m_cfg[11:7]));
    endtask

    // op: 0 cfg write, 1 enable write, 2 tx write, 3 rx read
    task automatic do_op(input int op, input logic [31:0] v);
        int s0, t0, r0;
        s0 = n_start; t0 = ev_tx; r0 = ev_rx;
        e_start = 0; e_tx = 0; e_rx = 0;
        wdata = v;
        case (op)
            0: cfg_wr = 1'b1;
            1: ctrl_wr = 1'b1;
            2: tx_wr = 1'b1;
            default: begin
                rx_rd = 1'b1;
                check(rx_q == m_rx, "R5", "rx read data", rx_q, m_rx);
            end
        endcase
        @(negedge clk);
        cfg_wr = 1'b0; ctrl_wr = 1'b0; tx_wr = 1'b0; rx_rd = 1'b0;
        case (op)
            0: m_cfg = v[22:0];
            1: begin
                if (v[0] && !m_en) begin
                    m_en = 1'b1;
                    model_run();
                end else m_en = v[0];
            end
            2: begin
                m_tx = v;
                m_stat[1] = 1'b0;
                model_run();
            end
            default: begin
                m_stat[0] = 1'b0;
                model_run();
            end
        endcase
        settle_and_compare(s0, t0, r0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(cfg_q == 23'h060000, "R1", "reset config", 32'(cfg_q), 32'h060000);
        check(stat_q == 3'b010, "R1", "reset status", 32'(stat_q), 32'h2);
        check(!en_q && tx_q == 0 && rx_q == 0, "R1", "reset enable/words",
              32'({en_q, |tx_q, |rx_q}), 32'h0);
        check(!shift_start && !tx_dreq && !rx_dreq && !irq_tx_ev && !irq_rx_ev, "R1",
              "reset outputs", 32'({shift_start, tx_dreq, rx_dreq, irq_tx_ev, irq_rx_ev}), 32'h0);

        // directed: R3 tx write while disabled starts nothing, enable edge does
        do_op(0, 32'h0000_C380);          // duplex, wl=7, both DMA enables
        do_op(2, 32'h1234_5678);
        do_op(1, 32'h1);                  // R3 rising edge runs the exchange
        do_op(1, 32'h1);                  // R3 no edge: no attempt
        do_op(3, 32'h0);                  // R5 read clears rxf, txe blocks (R4)
        solo_mode = 1'b1;
        do_op(2, 32'hCAFE_F00D);          // R6 no shift in single mode
        do_op(3, 32'h0);
        do_op(0, 32'h0010_C380);          // R6 force bit set
        do_op(2, 32'h0BAD_BEEF);
        do_op(0, 32'h0000_2100);          // R2 wl=2 flagged, tx-only mode
        do_op(3, 32'h0);
        solo_mode = 1'b0;
        do_op(0, 32'h0000_0380);
        do_op(3, 32'h0);

        // R10: rx read lands while the engine is busy
        begin
            int s0, t0, r0;
            s0 = n_start; t0 = ev_tx; r0 = ev_rx;
            wdata = 32'h5566_7788;
            tx_wr = 1'b1;
            @(negedge clk);
            tx_wr = 1'b0;
            @(negedge clk);
            rx_rd = 1'b1;
            @(negedge clk);
            rx_rd = 1'b0;
            repeat (12) @(negedge clk);
            check(n_start - s0 == 1, "R10", "single start", 32'(n_start - s0), 32'd1);
            check(stat_q == 3'b111, "R10", "status after deferred read", 32'(stat_q), 32'h7);
            check(ev_tx - t0 == 2, "R10", "tx events", 32'(ev_tx - t0), 32'd2);
            check(ev_rx - r0 == 2, "R10", "rx events", 32'(ev_rx - r0), 32'd2);
            check(rx_q == scramble(32'h5566_7788), "R10", "rx word", rx_q,
                  scramble(32'h5566_7788));
            m_stat = 3'b111; m_tx = '0; m_rx = scramble(32'h5566_7788);
        end

        // random operations
        for (int i = 0; i < N_RANDOM; i++) begin
            int sel;
            logic [31:0] v;
            sel = $urandom_range(0, 9);
            v = $urandom;
            case (sel)
                0, 1: do_op(0, v & 32'h007F_FFFF);
                2:    do_op(1, {31'd0, ($urandom_range(0, 3) != 0)});
                3, 4, 5: do_op(2, v);
                6, 7: do_op(3, 32'h0);
                8: begin
                    solo_mode = ~solo_mode;
                    do_op(3, 32'h0);
                end
                default: do_op(0, v & 32'h0038_F17F);
            endcase
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule